// File: doc/BRIEF.md
# E1 Loss-of-Signal and Receive Rail Conditioner

This block sits behind an E1 line receiver that has already split the received AMI signal into two unipolar rails, one for positive and one for negative pulses. It takes one sample of both rails for each bit period, qualified by a per-bit enable at 2048 kb/s that runs on the recovered clock. A bit period with a pulse on either rail counts as a one. A bit period with no pulse on either rail counts as a zero.

The block declares loss of signal after a long run of zeros. It withdraws the declaration only when the ones density over a two-frame window shows the line has recovered. It drives the two rail outputs toward a framer, with optional logical inversion, and forces them to a fixed level while loss is declared. It also drives a combined data output that neither the inversion nor the loss state affects. A polarity-select input chooses whether the loss output is low-true or high-true.

Top module: `e1_los_conditioner`

## Requirements
- R1: A synchronous active-high reset declares loss of signal, clears both counters and drives `pos_out`, `neg_out` and `data_out` low.
- R2: Loss of signal is declared on the 128th consecutive zero bit period. After 127 zeros followed by a one, no loss is declared.
- R3: A pulse on either rail ends a zero run, so the next zero starts a new run at a count of one.
- R4: While loss is declared, ones are counted in back-to-back 512-bit windows. The first window starts at the first bit after reset or after loss is declared. Loss clears on the bit that brings a window's count to 64, and this holds on the last bit of a window too. Otherwise the count drops to zero once the window ends.
- R5: `los_out` is low while loss is declared and high otherwise when `los_pol` is 1. It has the opposite sense when `los_pol` is 0.
- R6: With no loss declared, `inv_n` = 1 passes each rail to its output unchanged, and `inv_n` = 0 drives each output as the complement of its rail.
- R7: While loss is declared, `pos_out` and `neg_out` are both 1 when `inv_n` = 0 and both 0 when `inv_n` = 1.
- R8: `data_out` is the OR of the two input rails for each bit, whatever the values of `inv_n` and the loss state.
- R9: A bit with pulses on both rails counts as a single one. Outside loss, both rails still reach the outputs.
- R10: Counters, the loss state and all outputs change only on clock edges where `bit_en` is 1. `los_out` also follows `los_pol` directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle enable marking each received bit period |
| rx_pos | input | 1 | Positive-pulse rail sample |
| rx_neg | input | 1 | Negative-pulse rail sample |
| inv_n | input | 1 | Rail inversion control, 0 inverts the rail outputs |
| los_pol | input | 1 | Loss output polarity, 1 makes it low-true |
| pos_out | output | 1 | Conditioned positive rail, registered |
| neg_out | output | 1 | Conditioned negative rail, registered |
| data_out | output | 1 | OR of both rails, registered |
| los_out | output | 1 | Loss-of-signal indication |

## Verification
The recovery decision and the window restart can fall on the same bit, when the 64th one lands on the last bit of a 512-bit window. The bench provokes this by entering loss and sending 448 zeros and then 64 ones, and it expects loss to clear on that final bit. It then repeats the test shifted by one bit: 449 zeros and 63 ones. Here the window must close without clearing, and one further one must leave loss still declared, because the count has restarted.

// File: rtl/e1_los_pkg.sv
package e1_los_pkg;

  typedef struct packed {
    logic pos;
    logic neg;
  } rail_pair_t;

  localparam int unsigned NUM_RAILS = 2;

  function automatic logic pulse_seen(rail_pair_t r);
    return r.pos | r.neg;
  endfunction

endpackage

// File: rtl/e1_zero_run_det.sv
module e1_zero_run_det #(
  parameter int unsigned ZERO_RUN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic is_one,
  input  logic los_active,
  output logic run_hit
);
  localparam int unsigned ZW = $clog2(ZERO_RUN + 1);

  logic [ZW-1:0] run_cnt;

  // Hit on the bit that would complete the run.
  assign run_hit = bit_en && !los_active && !is_one &&
                   (run_cnt == ZW'(ZERO_RUN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (bit_en) begin
      if (is_one || los_active) begin
        run_cnt <= '0;
      end else if (run_cnt != ZW'(ZERO_RUN)) begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/e1_density_recover.sv
module e1_density_recover #(
  parameter int unsigned ONES_NEEDED = 64,
  parameter int unsigned WINDOW_BITS = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic is_one,
  input  logic los_active,
  output logic recover
);
  localparam int unsigned WW = $clog2(WINDOW_BITS);
  localparam int unsigned OW = $clog2(ONES_NEEDED + 1);

  logic [WW-1:0] win_pos;
  logic [OW-1:0] ones_cnt;
  logic          win_last;

  assign win_last = (win_pos == WW'(WINDOW_BITS - 1));
  // Recovery takes priority over the window restart on the last bit.
  assign recover  = bit_en && los_active && is_one &&
                    (ones_cnt == OW'(ONES_NEEDED - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_pos  <= '0;
      ones_cnt <= '0;
    end else if (bit_en) begin
      if (!los_active || recover || win_last) begin
        win_pos  <= '0;
        ones_cnt <= '0;
      end else begin
        win_pos <= win_pos + 1'b1;
        if (is_one && ones_cnt != OW'(ONES_NEEDED)) begin
          ones_cnt <= ones_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/e1_rail_cond.sv
module e1_rail_cond
  import e1_los_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  rail_pair_t rx,
  input  logic       inv_n,
  input  logic       los_next,
  output logic       pos_out,
  output logic       neg_out,
  output logic       data_out
);
  logic [NUM_RAILS-1:0] rail_in;
  logic [NUM_RAILS-1:0] rail_q;

  assign rail_in = {rx.pos, rx.neg};

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    always_ff @(posedge clk) begin
      if (rst) begin
        rail_q[g] <= 1'b0;
      end else if (bit_en) begin
        if (los_next) begin
          rail_q[g] <= ~inv_n;
        end else begin
          rail_q[g] <= inv_n ? rail_in[g] : ~rail_in[g];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= 1'b0;
    end else if (bit_en) begin
      data_out <= pulse_seen(rx);
    end
  end

  assign pos_out = rail_q[1];
  assign neg_out = rail_q[0];
endmodule

// File: rtl/e1_los_conditioner.sv
module e1_los_conditioner
  import e1_los_pkg::*;
#(
  parameter int unsigned ZERO_RUN    = 128,
  parameter int unsigned ONES_NEEDED = 64,
  parameter int unsigned WINDOW_BITS = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx_pos,
  input  logic rx_neg,
  input  logic inv_n,
  input  logic los_pol,
  output logic pos_out,
  output logic neg_out,
  output logic data_out,
  output logic los_out
);
  rail_pair_t rx;
  logic       is_one;
  logic       los_q;
  logic       los_next;
  logic       run_hit;
  logic       recover;
  logic       los_n;

  assign rx.pos = rx_pos;
  assign rx.neg = rx_neg;
  assign is_one = pulse_seen(rx);

  e1_zero_run_det #(.ZERO_RUN(ZERO_RUN)) i_zero_run (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .is_one     (is_one),
    .los_active (los_q),
    .run_hit    (run_hit)
  );

  e1_density_recover #(
    .ONES_NEEDED (ONES_NEEDED),
    .WINDOW_BITS (WINDOW_BITS)
  ) i_recover (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .is_one     (is_one),
    .los_active (los_q),
    .recover    (recover)
  );

  always_comb begin
    los_next = los_q;
    if (run_hit)      los_next = 1'b1;
    else if (recover) los_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) los_q <= 1'b1;
    else     los_q <= los_next;
  end

  e1_rail_cond i_rails (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .rx       (rx),
    .inv_n    (inv_n),
    .los_next (los_next),
    .pos_out  (pos_out),
    .neg_out  (neg_out),
    .data_out (data_out)
  );

  // Internal indication is low-true; polarity select 0 flips it.
  assign los_n   = ~los_q;
  assign los_out = los_pol ? los_n : ~los_n;
endmodule

// File: rtl/e1_los_conditioner_chk.sv
module e1_los_conditioner_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic rx_pos,
  input logic rx_neg,
  input logic inv_n,
  input logic los_q,
  input logic pos_out,
  input logic neg_out,
  input logic data_out
);
  a_r6_pass_through: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> (los_q ||
      (pos_out == ($past(inv_n) ? $past(rx_pos) : ~$past(rx_pos)) &&
       neg_out == ($past(inv_n) ? $past(rx_neg) : ~$past(rx_neg)))));

  a_r7_forced_level: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> (!los_q ||
      (pos_out == ~$past(inv_n) && neg_out == ~$past(inv_n))));

  a_r8_data_or: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> (data_out == ($past(rx_pos) | $past(rx_neg))));

  a_r3_one_never_sets: assert property (@(posedge clk) disable iff (rst)
    (bit_en && (rx_pos || rx_neg) && !los_q) |=> !los_q);

  a_r4_clear_on_one: assert property (@(posedge clk) disable iff (rst)
    $fell(los_q) |-> ($past(bit_en) && ($past(rx_pos) || $past(rx_neg))));

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(los_q) && $stable(pos_out) &&
                 $stable(neg_out) && $stable(data_out)));
endmodule

bind e1_los_conditioner e1_los_conditioner_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_en   (bit_en),
  .rx_pos   (rx_pos),
  .rx_neg   (rx_neg),
  .inv_n    (inv_n),
  .los_q    (los_q),
  .pos_out  (pos_out),
  .neg_out  (neg_out),
  .data_out (data_out)
);

// File: tb/test_e1_los_conditioner.sv
module test_e1_los_conditioner;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic rx_pos = 1'b0;
  logic rx_neg = 1'b0;
  logic inv_n = 1'b1;
  logic los_pol = 1'b1;
  logic pos_out, neg_out, data_out, los_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  e1_los_conditioner i_e1_los_conditioner (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .inv_n(inv_n), .los_pol(los_pol), .pos_out(pos_out), .neg_out(neg_out),
    .data_out(data_out), .los_out(los_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One bit period: inputs set on a falling edge, sampled at the next rise.
  task automatic send_bit(input logic p, input logic n);
    @(negedge clk);
    rx_pos = p; rx_neg = n; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_run(input int count, input logic p, input logic n);
    for (int i = 0; i < count; i++) send_bit(p, n);
  endtask

  // With los_pol = 1, los_out low means loss is declared.
  function automatic int in_loss();
    return (los_out == 1'b0) ? 1 : 0;
  endfunction

  task automatic t_reset();
    check("R1 reset loss", in_loss(), 1);
    check("R1 reset pos_out", pos_out, 0);
    check("R1 reset neg_out", neg_out, 0);
    check("R1 reset data_out", data_out, 0);
  endtask

  task automatic t_recover_from_reset();
    send_run(63, 1'b1, 1'b0);
    check("R4 63 ones keep loss", in_loss(), 1);
    check("R7 forced low inv_n=1", {pos_out, neg_out}, 0);
    check("R8 data during loss", data_out, 1);
    send_bit(1'b1, 1'b0);
    check("R4 64th one clears", in_loss(), 0);
    check("R6 pass after clear", {pos_out, neg_out}, 2);
  endtask

  task automatic t_rails();
    inv_n = 1'b1;
    send_bit(1'b0, 1'b1);
    check("R6 pass neg", {pos_out, neg_out}, 1);
    check("R8 data neg", data_out, 1);
    send_bit(1'b1, 1'b1);
    check("R9 violation both rails pass", {pos_out, neg_out}, 3);
    send_bit(1'b0, 1'b0);
    check("R8 data zero", data_out, 0);
    inv_n = 1'b0;
    send_bit(1'b1, 1'b0);
    check("R6 inverted", {pos_out, neg_out}, 1);
    check("R8 data ignores inv_n", data_out, 1);
    send_bit(1'b0, 1'b0);
    check("R6 inverted zero", {pos_out, neg_out}, 3);
    check("R8 data zero inverted", data_out, 0);
    inv_n = 1'b1;
  endtask

  task automatic t_zero_run();
    send_bit(1'b1, 1'b0);
    send_run(127, 1'b0, 1'b0);
    check("R2 127 zeros no loss", in_loss(), 0);
    send_bit(1'b0, 1'b1);
    check("R3 one breaks run", in_loss(), 0);
    send_run(127, 1'b0, 1'b0);
    check("R3 run restarted", in_loss(), 0);
    send_bit(1'b0, 1'b0);
    check("R2 128th zero sets loss", in_loss(), 1);
    // Two ones are now counted in the first window.
    send_bit(1'b1, 1'b0);
    check("R7 forced low", {pos_out, neg_out}, 0);
    check("R8 data in loss", data_out, 1);
    inv_n = 1'b0;
    send_bit(1'b1, 1'b0);
    check("R7 forced high inv_n=0", {pos_out, neg_out}, 3);
    inv_n = 1'b1;
    send_run(61, 1'b1, 1'b0);
    check("R4 63 total ones keep loss", in_loss(), 1);
    send_bit(1'b1, 1'b0);
    check("R4 64 total ones clear", in_loss(), 0);
  endtask

  task automatic enter_loss();
    send_run(128, 1'b0, 1'b0);
    check("R2 enter loss", in_loss(), 1);
  endtask

  task automatic t_violation_count();
    enter_loss();
    send_run(63, 1'b1, 1'b1);
    check("R9 63 double bits keep loss", in_loss(), 1);
    send_bit(1'b1, 1'b1);
    check("R9 64th double bit clears", in_loss(), 0);
  endtask

  task automatic t_window_restart();
    enter_loss();
    send_run(63, 1'b1, 1'b0);
    send_run(449, 1'b0, 1'b0);
    check("R4 window ends short", in_loss(), 1);
    send_run(63, 1'b0, 1'b1);
    check("R4 count restarted", in_loss(), 1);
    send_bit(1'b0, 1'b1);
    check("R4 clear in second window", in_loss(), 0);
  endtask

  task automatic t_boundary();
    enter_loss();
    send_run(448, 1'b0, 1'b0);
    send_run(63, 1'b1, 1'b0);
    check("R4 before last bit", in_loss(), 1);
    send_bit(1'b1, 1'b0);
    check("R4 clear on last window bit", in_loss(), 0);
    enter_loss();
    send_run(449, 1'b0, 1'b0);
    send_run(63, 1'b1, 1'b0);
    check("R4 63 at window end", in_loss(), 1);
    send_bit(1'b1, 1'b0);
    check("R4 no carry across windows", in_loss(), 1);
  endtask

  task automatic t_polarity();
    los_pol = 1'b0;
    #1;
    check("R5 inverted during loss", los_out, 1);
    send_run(63, 1'b1, 1'b0);
    check("R5 inverted after clear", los_out, 0);
    los_pol = 1'b1;
    #1;
    check("R5 normal after clear", los_out, 1);
  endtask

  task automatic t_enable_gate();
    send_bit(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rx_pos = i[0]; rx_neg = ~i[0];
    end
    check("R10 rails hold", {pos_out, neg_out}, 2);
    check("R10 data holds", data_out, 1);
    rx_pos = 1'b0; rx_neg = 1'b0;
    repeat (300) @(negedge clk);
    check("R10 idle zeros no loss", in_loss(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_recover_from_reset();
    t_rails();
    t_zero_run();
    t_violation_count();
    t_window_restart();
    t_boundary();
    t_polarity();
    t_enable_gate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule